// File: doc/BRIEF.md
# NOR Flash Erase and Suspend Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. It takes one request at a time over a valid/ready handshake and turns it into flash bus cycles. There are four kinds of request: erase the whole array, erase one sector, suspend a running program, and resume it. An erase is sent as a framed series of six write cycles. The block then watches the embedded erase by reading the status word again and again. When the erase ends, it reports done, with an error flag when the flash signals a timeout.

A suspend is a single command write. After it, the block stays busy for a fixed settle time, taken from a clock-frequency parameter, so that the host cannot read the flash before the device is ready. While the program stays suspended, a read-permission output tells the host whether a given address may be read. Reads inside the suspended sector are refused, and reads of every other sector are allowed. A resume is a single command write. It clears the suspended state.

Top module: `nfs_top`

## Requirements
- R1: After reset, reqReady is 1; busy, done and error are 0; fCeN, fWeN and fOeN are all 1; rdGrant is 1 for every address.
- R2: A request is taken only on a clock edge where reqValid and reqReady are both 1. From that edge until the cycle after done, reqReady is 0 and busy is 1, so no other request can start and no other command reaches the bus while an erase runs.
- R3: A chip erase request (reqOp 0) issues exactly six writes, in order: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h (address/data, word mode).
- R4: A sector erase request (reqOp 1) issues the same first five writes. The sixth write carries reqAddr on the address bus and 30h on the data bus.
- R5: Every write cycle lasts STROBE_CYC+2 clocks. fCeN is 0 for the whole cycle. fWeN is 0 for exactly STROBE_CYC clocks, after one setup clock and before one hold clock. fWeN and fOeN are never 0 at the same time.
- R6: A suspend request (reqOp 2) issues one write of B0h at reqAddr. done follows STROBE_CYC+2+CLK_MHZ*SETTLE_US clocks after the accepting edge.
- R7: A resume request (reqOp 3) issues one write of 30h at reqAddr. done follows STROBE_CYC+2 clocks after the accepting edge, and the suspended state is cleared.
- R8: After the sixth erase write, the block runs read cycles at the request address with the same length as a write cycle. It stops at the first read whose DQ6 (bit 6) equals DQ6 of the read before it. With R reads, done follows 6*(STROBE_CYC+2)+R*(STROBE_CYC+2) clocks after the accepting edge, with error 0.
- R9: If a status read has DQ6 different from the read before it and DQ5 (bit 5) is 1, the block ends the erase with done and error both 1 in the same cycle.
- R10: rdGrant is 0 while busy. When idle and not suspended, it is 1 for every address. When idle and suspended, it is 0 when rdAddr lies in the sector of the suspend address (bits ADDR_W-1 down to SECT_LSB) and 1 otherwise.
- R11: A reset during an erase returns the block to idle at once, with no done. A later erase request issues the full six-write sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqOp | input | 2 | 0 chip erase, 1 sector erase, 2 suspend, 3 resume |
| reqAddr | input | ADDR_W | Sector address for erase; target address for suspend and resume |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Valid with done; erase timed out |
| rdAddr | input | ADDR_W | Address the host wants to read |
| rdGrant | output | 1 | Reading rdAddr is currently allowed |
| fCeN | output | 1 | Flash chip enable, active low |
| fWeN | output | 1 | Flash write strobe, active low |
| fOeN | output | 1 | Flash output enable, active low |
| fAddr | output | ADDR_W | Flash address bus |
| fDqOut | output | DATA_W | Data driven to the flash |
| fDqOe | output | 1 | Drive enable for fDqOut |
| fDqIn | input | DATA_W | Data read from the flash |

## Verification
Each result has a fixed due time, counted in clocks from the edge that accepts the request. With the default four-clock bus cycle, done is due 4 clocks later for a resume and 4 plus the settle count for a suspend. For an erase that needs R status reads, done is due 24 plus 4*R clocks later. reqReady returns one clock after done. For every request, the bench works out this due time from the status pattern its flash model will return. It then samples done, error, busy, reqReady and rdGrant on the falling edge of each clock in the window, so each value is checked in the exact cycle it must change. The write cycles are captured as they happen, on the rising edge of the write strobe, and compared with the expected address/data list once the request completes.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

  typedef enum logic [1:0] {
    OP_CHIP = 2'd0,
    OP_SECT = 2'd1,
    OP_SUSP = 2'd2,
    OP_RESM = 2'd3
  } opKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;
    logic load;
    logic busWr;
    logic busRd;
    logic stepInc;
    logic pollInit;
    logic waitLoad;
    logic waitRun;
    logic setSusp;
    logic clrSusp;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    opKind_t op;
    logic    cycEnd;
    logic    stepLast;
    logic    dqSame;
    logic    dqFail;
    logic    waitZero;
  } dpStatus_t;

endpackage

// File: rtl/nfs_ctrl.sv
module nfs_ctrl
  import nfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  dpStatus_t  st,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       done,
  output logic       error
);

  typedef enum logic [2:0] {S_IDLE, S_WRITE, S_POLL, S_WAIT, S_DONE} state_t;

  state_t state, nextState;
  logic   errSet;

  always_comb begin
    ctl       = '0;
    nextState = state;
    errSet    = 1'b0;
    unique case (state)
      S_IDLE: begin
        ctl.idle = 1'b1;
        if (reqValid) begin
          ctl.load  = 1'b1;
          nextState = S_WRITE;
        end
      end
      S_WRITE: begin
        ctl.busWr = 1'b1;
        if (st.cycEnd) begin
          if (!st.stepLast) begin
            ctl.stepInc = 1'b1;
          end else begin
            unique case (st.op)
              OP_CHIP, OP_SECT: begin
                ctl.pollInit = 1'b1;
                nextState    = S_POLL;
              end
              OP_SUSP: begin
                ctl.waitLoad = 1'b1;
                ctl.setSusp  = 1'b1;
                nextState    = S_WAIT;
              end
              default: begin
                ctl.clrSusp = 1'b1;
                nextState   = S_DONE;
              end
            endcase
          end
        end
      end
      S_POLL: begin
        ctl.busRd = 1'b1;
        if (st.cycEnd) begin
          if (st.dqSame) begin
            nextState = S_DONE;
          end else if (st.dqFail) begin
            errSet    = 1'b1;
            nextState = S_DONE;
          end
        end
      end
      S_WAIT: begin
        ctl.waitRun = 1'b1;
        if (st.waitZero) nextState = S_DONE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      error <= 1'b0;
    end else begin
      state <= nextState;
      error <= errSet;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  // R2: completion is a single-cycle pulse
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: an error is only flagged together with done
  a_r9_error_with_done: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

endmodule

// File: rtl/nfs_datapath.sv
module nfs_datapath
  import nfs_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int STROBE_CYC = 2,
  parameter int SUSP_CYC   = 1875,
  parameter int SECT_LSB   = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] fDqIn,
  output dpStatus_t         st,
  output logic              rdGrant,
  output logic              fCeN,
  output logic              fWeN,
  output logic              fOeN,
  output logic [ADDR_W-1:0] fAddr,
  output logic [DATA_W-1:0] fDqOut,
  output logic              fDqOe
);

  localparam int CYC_LEN = STROBE_CYC + 2;
  localparam int TW      = $clog2(CYC_LEN);
  localparam int WW      = $clog2(SUSP_CYC + 1);
  localparam int SECT_W  = ADDR_W - SECT_LSB;
  localparam logic [ADDR_W-1:0] UNLOCK_A = ADDR_W'('h555);
  localparam logic [ADDR_W-1:0] UNLOCK_B = ADDR_W'('h2AA);

  opKind_t           opReg;
  logic [ADDR_W-1:0] addrReg;
  logic [2:0]        step;
  logic [TW-1:0]     tCnt;
  logic [WW-1:0]     waitCnt;
  logic              curDq6, curDq5, prevDq6, havePrev;
  logic              suspended;
  logic [SECT_W-1:0] suspSect;
  logic              busOn, strobeWin;
  logic [ADDR_W-1:0] stepAddr;
  logic [7:0]        stepCode;

  assign busOn     = ctl.busWr | ctl.busRd;
  assign strobeWin = (tCnt >= TW'(1)) && (tCnt <= TW'(STROBE_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg     <= OP_CHIP;
      addrReg   <= '0;
      step      <= '0;
      tCnt      <= '0;
      waitCnt   <= '0;
      curDq6    <= 1'b0;
      curDq5    <= 1'b0;
      prevDq6   <= 1'b0;
      havePrev  <= 1'b0;
      suspended <= 1'b0;
      suspSect  <= '0;
    end else begin
      if (ctl.load) begin
        opReg   <= opKind_t'(reqOp);
        addrReg <= reqAddr;
        step    <= '0;
      end else if (ctl.stepInc) begin
        step <= step + 3'd1;
      end

      if (!busOn || st.cycEnd) tCnt <= '0;
      else                     tCnt <= tCnt + TW'(1);

      if (ctl.busRd && tCnt == TW'(STROBE_CYC)) begin
        curDq6 <= fDqIn[6];
        curDq5 <= fDqIn[5];
      end

      if (ctl.pollInit) begin
        havePrev <= 1'b0;
      end else if (ctl.busRd && st.cycEnd) begin
        prevDq6  <= curDq6;
        havePrev <= 1'b1;
      end

      if (ctl.waitLoad)                   waitCnt <= WW'(SUSP_CYC - 1);
      else if (ctl.waitRun && !st.waitZero) waitCnt <= waitCnt - WW'(1);

      if (ctl.setSusp) begin
        suspended <= 1'b1;
        suspSect  <= addrReg[ADDR_W-1:SECT_LSB];
      end else if (ctl.clrSusp) begin
        suspended <= 1'b0;
      end
    end
  end

  // command framing per step
  always_comb begin
    stepAddr = addrReg;
    stepCode = 8'h00;
    if (opReg == OP_SUSP) begin
      stepCode = 8'hB0;
    end else if (opReg == OP_RESM) begin
      stepCode = 8'h30;
    end else begin
      unique case (step)
        3'd0, 3'd3: begin stepAddr = UNLOCK_A; stepCode = 8'hAA; end
        3'd1, 3'd4: begin stepAddr = UNLOCK_B; stepCode = 8'h55; end
        3'd2:       begin stepAddr = UNLOCK_A; stepCode = 8'h80; end
        default: begin
          if (opReg == OP_CHIP) begin
            stepAddr = UNLOCK_A;
            stepCode = 8'h10;
          end else begin
            stepCode = 8'h30;
          end
        end
      endcase
    end
  end

  assign st.op       = opReg;
  assign st.cycEnd   = busOn && (tCnt == TW'(CYC_LEN - 1));
  assign st.stepLast = (opReg == OP_CHIP || opReg == OP_SECT) ? (step == 3'd5) : (step == 3'd0);
  assign st.dqSame   = havePrev && (curDq6 == prevDq6);
  assign st.dqFail   = havePrev && (curDq6 != prevDq6) && curDq5;
  assign st.waitZero = (waitCnt == '0);

  assign rdGrant = ctl.idle && !(suspended && rdAddr[ADDR_W-1:SECT_LSB] == suspSect);

  assign fCeN   = !busOn;
  assign fWeN   = !(ctl.busWr && strobeWin);
  assign fOeN   = !(ctl.busRd && strobeWin);
  assign fDqOe  = ctl.busWr;
  assign fAddr  = ctl.busWr ? stepAddr : (ctl.busRd ? addrReg : '0);
  assign fDqOut = ctl.busWr ? DATA_W'(stepCode) : '0;

  // R5: write and read strobes never overlap
  a_r5_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!fWeN && !fOeN));

  // R5: write strobe stays low for at least two clocks once it falls
  a_r5_we_min_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fWeN) |=> !fWeN);

  // R6: settle counter steps down by one each waiting clock
  a_r6_wait_counts: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.waitRun && waitCnt != '0) |=> (waitCnt == $past(waitCnt) - WW'(1)));

  // R2: the latched request stays put while polling
  a_r2_op_held: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busRd |=> $stable(opReg) && $stable(addrReg));

endmodule

// File: rtl/nfs_top.sv
module nfs_top
  import nfs_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int STROBE_CYC = 2,
  parameter int CLK_MHZ    = 125,
  parameter int SETTLE_US  = 15,
  parameter int SECT_LSB   = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              busy,
  output logic              done,
  output logic              error,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdGrant,
  output logic              fCeN,
  output logic              fWeN,
  output logic              fOeN,
  output logic [ADDR_W-1:0] fAddr,
  output logic [DATA_W-1:0] fDqOut,
  output logic              fDqOe,
  input  logic [DATA_W-1:0] fDqIn
);

  localparam int SUSP_CYC = CLK_MHZ * SETTLE_US;

  ctlStrobe_t ctl;
  dpStatus_t  st;

  nfs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .st       (st),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  nfs_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STROBE_CYC (STROBE_CYC),
    .SUSP_CYC   (SUSP_CYC),
    .SECT_LSB   (SECT_LSB)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqOp   (reqOp),
    .reqAddr (reqAddr),
    .rdAddr  (rdAddr),
    .fDqIn   (fDqIn),
    .st      (st),
    .rdGrant (rdGrant),
    .fCeN    (fCeN),
    .fWeN    (fWeN),
    .fOeN    (fOeN),
    .fAddr   (fAddr),
    .fDqOut  (fDqOut),
    .fDqOe   (fDqOe)
  );

  assign reqReady = ctl.idle;

endmodule

// File: tb/nfs_top_tb.sv
`timescale 1ns/1ps
module nfs_top_tb;

  localparam int AW = 22;
  localparam int DW = 16;
  localparam int STB = 2;
  localparam int CYC = STB + 2;
  localparam int SUSP = 125 * 15;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqOp = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic          busy, done, error;
  logic [AW-1:0] rdAddr = '0;
  logic          rdGrant;
  logic          fCeN, fWeN, fOeN, fDqOe;
  logic [AW-1:0] fAddr;
  logic [DW-1:0] fDqOut;
  logic [DW-1:0] fDqIn = '0;

  int nChecks = 0;
  int nFail = 0;
  int rdIdx = 0;
  int togN = 0;
  int dq5From = 1000000;
  int weLow = 0;
  logic [AW+DW-1:0] wrQ[$];
  logic [AW+DW-1:0] expQ[$];

  always #4 clk = ~clk;

  nfs_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .busy(busy), .done(done), .error(error),
    .rdAddr(rdAddr), .rdGrant(rdGrant), .fCeN(fCeN), .fWeN(fWeN), .fOeN(fOeN),
    .fAddr(fAddr), .fDqOut(fDqOut), .fDqOe(fDqOe), .fDqIn(fDqIn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flash model: status word per read index
  always @(negedge fOeN) begin
    rdIdx++;
    fDqIn = '0;
    fDqIn[6] = (rdIdx <= togN + 1) ? rdIdx[0] : ((togN + 1) % 2 == 1);
    fDqIn[5] = (rdIdx >= dq5From);
  end

  always @(negedge clk) if (rstN && !fWeN) weLow++;

  always @(posedge fWeN) begin
    if (rstN) begin
      wrQ.push_back({fAddr, fDqOut});
      chk(weLow == STB, "R5", "write strobe width", weLow, STB);
      chk(fCeN == 1'b0 && fOeN == 1'b1 && fDqOe == 1'b1, "R5", "ce/oe/drive during write",
          {fCeN, fOeN, fDqOe}, 3'b011);
    end
    weLow = 0;
  end

  function automatic logic [AW+DW-1:0] wv(input int a, input int d);
    return {AW'(a), DW'(d)};
  endfunction

  task automatic buildErase(input bit sect, input logic [AW-1:0] a);
    expQ.delete();
    expQ.push_back(wv('h555, 'hAA));
    expQ.push_back(wv('h2AA, 'h55));
    expQ.push_back(wv('h555, 'h80));
    expQ.push_back(wv('h555, 'hAA));
    expQ.push_back(wv('h2AA, 'h55));
    if (sect) expQ.push_back({a, DW'('h30)});
    else      expQ.push_back(wv('h555, 'h10));
  endtask

  // drive one request and compare the whole response window clock by clock
  task automatic runOp(input logic [1:0] op, input logic [AW-1:0] a, input int lat,
                       input bit expErr, input bit hold, input string req);
    wrQ.delete();
    rdIdx = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a;
    @(posedge clk);
    for (int j = 0; j <= lat + 1; j++) begin
      @(negedge clk);
      if (j == 0) begin
        if (hold) reqOp = 2'd2;
        else reqValid = 1'b0;
      end
      if (j == lat) reqValid = 1'b0;
      chk(done == (j == lat), req, $sformatf("done at clock %0d", j), done, j == lat);
      chk(reqReady == (j == lat + 1), "R2", $sformatf("reqReady at clock %0d", j), reqReady, j == lat + 1);
      chk(busy == (j <= lat), "R2", $sformatf("busy at clock %0d", j), busy, j <= lat);
      if (j <= lat) chk(rdGrant == 1'b0, "R10", "grant while busy", rdGrant, 0);
      if (j == lat) chk(error == expErr, req, "error with done", error, expErr);
    end
    chk(wrQ.size() == expQ.size(), req, "write count", wrQ.size(), expQ.size());
    for (int k = 0; k < expQ.size() && k < wrQ.size(); k++)
      chk(wrQ[k] == expQ[k], req, $sformatf("write %0d addr/data", k), wrQ[k], expQ[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1 && busy == 0 && done == 0 && error == 0, "R1", "handshake/status",
        {reqReady, busy, done, error}, 4'b1000);
    chk(fCeN && fWeN && fOeN, "R1", "strobes idle", {fCeN, fWeN, fOeN}, 3'b111);
    rdAddr = 22'h3F_0000;
    #1 chk(rdGrant == 1, "R10", "grant after reset", rdGrant, 1);
    chk(rdGrant == 1, "R1", "grant after reset", rdGrant, 1);

    // R3 chip erase, immediate stable status (two reads)
    togN = 0; dq5From = 1000000;
    buildErase(0, '0);
    runOp(2'd0, 22'h00_0000, 6*CYC + 2*CYC, 0, 0, "R3");

    // R4 + R8 sector erase with three toggles (five reads)
    togN = 3;
    buildErase(1, 22'h2A_1234);
    runOp(2'd1, 22'h2A_1234, 6*CYC + 5*CYC, 0, 0, "R8");
    chk(1, "R4", "sector erase sequence compared above", 0, 0);

    // R9 timeout: DQ5 up while DQ6 still toggling at read 3
    togN = 10; dq5From = 3;
    buildErase(0, '0);
    runOp(2'd0, 22'h00_0000, 6*CYC + 3*CYC, 1, 0, "R9");
    dq5From = 1000000;

    // R2 lockout: a suspend held on the request line during erase never reaches the bus
    togN = 1;
    buildErase(1, 22'h11_0000);
    runOp(2'd1, 22'h11_0000, 6*CYC + 3*CYC, 0, 1, "R2");

    // R6 suspend at sector 5, then grant checks
    expQ.delete(); expQ.push_back({22'h02_8010, DW'('hB0)});
    runOp(2'd2, 22'h02_8010, CYC + SUSP, 0, 0, "R6");
    rdAddr = 22'h02_FFFF;
    #1 chk(rdGrant == 0, "R10", "read in suspended sector", rdGrant, 0);
    rdAddr = 22'h03_0000;
    #1 chk(rdGrant == 1, "R10", "read in other sector", rdGrant, 1);

    // R7 resume clears suspension
    expQ.delete(); expQ.push_back({22'h00_0044, DW'('h30)});
    runOp(2'd3, 22'h00_0044, CYC, 0, 0, "R7");
    rdAddr = 22'h02_8000;
    #1 chk(rdGrant == 1, "R7", "grant after resume", rdGrant, 1);

    // R11 reset mid-erase, then reissue
    togN = 1000;
    wrQ.delete(); rdIdx = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; reqAddr = '0;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (40) @(negedge clk);
    rstN = 1'b0;
    #1 chk(reqReady == 1 && busy == 0 && done == 0, "R11", "idle during reset",
           {reqReady, busy, done}, 3'b100);
    chk(fCeN && fOeN && fWeN, "R11", "bus released", {fCeN, fOeN, fWeN}, 3'b111);
    @(negedge clk);
    rstN = 1'b1;
    togN = 0;
    buildErase(0, '0);
    runOp(2'd0, 22'h00_0000, 6*CYC + 2*CYC, 0, 0, "R11");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule